// File: doc/BRIEF.md
# PHY Management Bus Controller

This block lets a processor talk to Ethernet PHYs over the two-wire management bus: a clock line driven by the controller and a shared data line. Software sees six 32-bit registers on a small word-indexed port. It programs the PHY and register numbers once. A write frame starts when software stores a data word. A read frame starts when software sets the read command bit after it was clear. Software then polls a busy flag and, for reads, a separate not-valid flag that stays set until the read data can be fetched.

Inside there are three parts. A clock divider makes the management clock from the system clock and gives one-cycle strobes at its edges. A frame engine shifts each Clause 22 frame out on the data line and, for reads, samples the PHY's answer after releasing the line. A register bank decodes the accesses that start frames. A soft reset bit in the configuration register stops any frame at once and holds the bus quiet.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: Register index 0 is configuration (bit 31 soft reset, bits 2:0 divider), 1 is command (bit 0), 2 is address (PHY number in 12:8, register number in 4:0), 3 is write data (low 16 bits), 4 is read data (low 16 bits) and 5 is indication (bit 0 busy, bit 2 not valid). Unused bits and indices 6 and 7 read as 0. After reset configuration reads 7 and all other registers read 0.
- R2: A write to index 3 sends, MSB first, 32 ones, start 01, opcode 01, the 5-bit PHY number, the 5-bit register number, turnaround 10 and the 16 data bits, driving the data line for all 64 bits.
- R3: Setting command bit 0 sends the same header with opcode 10, releases the data line from the turnaround (bit 46) onward, samples 16 data bits from the PHY and makes them readable at index 4.
- R4: Indication bit 0 reads 1 from the access that starts a frame until the frame has finished on the wire, then 0.
- R5: Indication bit 2 is set by the access that starts a read and clears only when index 4 holds that read's data.
- R6: Writing 1 to command bit 0 while it already holds 1 starts no frame.
- R7: The management clock period is 2*(divider+1)*4 system clock cycles.
- R8: While configuration bit 31 is set, a frame in progress stops, the data line is released, busy reads 0, the management clock is held low and register accesses start no frame.
- R9: The data line changes only while the management clock is low, and the controller samples read data after the clock's rising edge.
- R10: An access that would start a frame while busy reads 1 starts none; the frame in flight keeps its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register word index |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
A bit counter or shift register that goes wrong shows up as a frame of the wrong length or with a misplaced field. The PHY model at the pins sees this within the 64 clock periods of that frame. A wrong launch decode shows up as a busy flag that rises when it should not, or fails to rise, on the indication read one cycle after the access. A not-valid flag that drops early would let software fetch stale data, and the indication and read-data registers expose this in the cycle after the frame ends. Soft reset errors show as an output enable or clock still active two cycles after the configuration write.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   localparam int REG_AW    = 3;
   localparam int PHY_AW    = 5;
   localparam int DATA_W    = 16;

   localparam logic [REG_AW-1:0] IDX_CFG  = 3'd0;
   localparam logic [REG_AW-1:0] IDX_CMD  = 3'd1;
   localparam logic [REG_AW-1:0] IDX_ADDR = 3'd2;
   localparam logic [REG_AW-1:0] IDX_WDAT = 3'd3;
   localparam logic [REG_AW-1:0] IDX_RDAT = 3'd4;
   localparam logic [REG_AW-1:0] IDX_IND  = 3'd5;

   localparam logic [1:0] OPC_WRITE = 2'b01;
   localparam logic [1:0] OPC_READ  = 2'b10;

   typedef enum logic [1:0] {
      ENG_IDLE = 2'd0,
      ENG_WAIT = 2'd1,
      ENG_RUN  = 2'd2
   } eng_state_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
   parameter int DIV_W    = 3,
   parameter int PRESCALE = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic [DIV_W-1:0] div_sel,
   output logic             mdc,
   output logic             mdc_rise,
   output logic             mdc_fall
);
   localparam int MAX_HALF = (2 ** DIV_W) * PRESCALE;
   localparam int CNT_W    = $clog2(MAX_HALF + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] half_m1;
   int               half_i;

   // Half period in system cycles is (setting+1)*PRESCALE.
   always_comb begin
      half_i  = (int'(div_sel) + 1) * PRESCALE - 1;
      half_m1 = CNT_W'(half_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         mdc      <= 1'b0;
         mdc_rise <= 1'b0;
         mdc_fall <= 1'b0;
      end else if (hold) begin
         cnt_q    <= '0;
         mdc      <= 1'b0;
         mdc_rise <= 1'b0;
         mdc_fall <= 1'b0;
      end else begin
         mdc_rise <= 1'b0;
         mdc_fall <= 1'b0;
         // >= keeps the divider sane when the setting drops mid-count.
         if (cnt_q >= half_m1) begin
            cnt_q    <= '0;
            mdc      <= ~mdc;
            mdc_rise <= ~mdc;
            mdc_fall <= mdc;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // R7 companion: strobes never coincide
   assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(mdc_rise && mdc_fall));
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
   import mdio_pkg::*;
#(
   parameter int PRE_LEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              abort,
   input  logic              launch,
   input  logic              launch_rd,
   input  logic [PHY_AW-1:0] phy_num,
   input  logic [PHY_AW-1:0] reg_num,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              mdc_rise,
   input  logic              mdc_fall,
   input  logic              mdio_i,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rd_word,
   output logic              mdio_o,
   output logic              mdio_oe
);
   localparam int TAIL_LEN  = 4 + 2 * PHY_AW + 2 + DATA_W;
   localparam int FRAME_LEN = PRE_LEN + TAIL_LEN;
   localparam int TA_POS    = PRE_LEN + 4 + 2 * PHY_AW;
   localparam int DATA_POS  = TA_POS + 2;
   localparam int CNT_W     = $clog2(FRAME_LEN);

   localparam logic [CNT_W:0]   TA_C   = (CNT_W + 1)'(TA_POS);
   localparam logic [CNT_W-1:0] DATA_C = CNT_W'(DATA_POS);
   localparam logic [CNT_W-1:0] LAST_C = CNT_W'(FRAME_LEN - 1);

   eng_state_t           state_q;
   logic [FRAME_LEN-1:0] tx_q;
   logic [FRAME_LEN-1:0] load_vec;
   logic [TAIL_LEN-1:0]  tail;
   logic [CNT_W-1:0]     bit_q;
   logic [DATA_W-1:0]    rx_q;
   logic                 is_rd_q;

   always_comb begin
      tail = {2'b01, (launch_rd ? OPC_READ : OPC_WRITE), phy_num, reg_num,
              2'b10, (launch_rd ? {DATA_W{1'b0}} : wr_data)};
   end

   generate
      if (PRE_LEN > 0) begin : g_pre
         assign load_vec = {{PRE_LEN{1'b1}}, tail};
      end else begin : g_nopre
         assign load_vec = tail;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ENG_IDLE;
         tx_q    <= '0;
         bit_q   <= '0;
         rx_q    <= '0;
         is_rd_q <= 1'b0;
         mdio_oe <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (abort) begin
            state_q <= ENG_IDLE;
            mdio_oe <= 1'b0;
         end else begin
            case (state_q)
               ENG_IDLE: begin
                  if (launch) begin
                     tx_q    <= load_vec;
                     is_rd_q <= launch_rd;
                     state_q <= ENG_WAIT;
                  end
               end
               ENG_WAIT: begin
                  // First bit goes out after a falling clock edge.
                  if (mdc_fall) begin
                     mdio_oe <= 1'b1;
                     bit_q   <= '0;
                     state_q <= ENG_RUN;
                  end
               end
               ENG_RUN: begin
                  if (mdc_fall) begin
                     tx_q  <= {tx_q[FRAME_LEN-2:0], 1'b0};
                     bit_q <= bit_q + 1'b1;
                     if (is_rd_q && ({1'b0, bit_q} + 1'b1) >= TA_C)
                        mdio_oe <= 1'b0;
                  end
                  if (mdc_rise) begin
                     if (is_rd_q && bit_q >= DATA_C)
                        rx_q <= {rx_q[DATA_W-2:0], mdio_i};
                     if (bit_q == LAST_C) begin
                        state_q <= ENG_IDLE;
                        mdio_oe <= 1'b0;
                        done    <= 1'b1;
                     end
                  end
               end
               default: state_q <= ENG_IDLE;
            endcase
         end
      end
   end

   assign busy    = (state_q != ENG_IDLE);
   assign mdio_o  = tx_q[FRAME_LEN-1];
   assign rd_word = rx_q;

   assert_read_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ENG_RUN && is_rd_q && {1'b0, bit_q} >= TA_C) |-> !mdio_oe);

   assert_busy_ends_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (done || $past(abort)));
endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
   import mdio_pkg::*;
#(
   parameter int DIV_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              eng_busy,
   input  logic              eng_done,
   input  logic [DATA_W-1:0] eng_rd_word,
   output logic              soft_rst,
   output logic [DIV_W-1:0]  div_sel,
   output logic              launch,
   output logic              launch_rd,
   output logic [PHY_AW-1:0] phy_num,
   output logic [PHY_AW-1:0] reg_num,
   output logic [DATA_W-1:0] wr_data
);
   logic              cfg_rst_q;
   logic [DIV_W-1:0]  cfg_div_q;
   logic              cmd_q;
   logic [PHY_AW-1:0] phy_q;
   logic [PHY_AW-1:0] regn_q;
   logic [DATA_W-1:0] wdat_q;
   logic [DATA_W-1:0] rdat_q;
   logic              nv_q;
   logic              pend_rd_q;
   logic              wr_wdat;
   logic              wr_cmd_set;
   logic              unused_wdata;

   assign unused_wdata = ^reg_wdata[30:DATA_W];

   assign wr_wdat    = reg_wr && (reg_addr == IDX_WDAT);
   assign wr_cmd_set = reg_wr && (reg_addr == IDX_CMD) && reg_wdata[0] && !cmd_q;
   assign launch     = !cfg_rst_q && !eng_busy && (wr_wdat || wr_cmd_set);
   assign launch_rd  = (reg_addr == IDX_CMD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_rst_q <= 1'b0;
         cfg_div_q <= '1;
         cmd_q     <= 1'b0;
         phy_q     <= '0;
         regn_q    <= '0;
         wdat_q    <= '0;
         rdat_q    <= '0;
         nv_q      <= 1'b0;
         pend_rd_q <= 1'b0;
      end else begin
         if (reg_wr) begin
            case (reg_addr)
               IDX_CFG: begin
                  cfg_rst_q <= reg_wdata[31];
                  cfg_div_q <= reg_wdata[DIV_W-1:0];
               end
               IDX_CMD:  cmd_q  <= reg_wdata[0];
               IDX_ADDR: begin
                  phy_q  <= reg_wdata[8 +: PHY_AW];
                  regn_q <= reg_wdata[0 +: PHY_AW];
               end
               IDX_WDAT: wdat_q <= reg_wdata[DATA_W-1:0];
               default: ;
            endcase
         end
         if (cfg_rst_q)
            pend_rd_q <= 1'b0;
         if (eng_done && pend_rd_q) begin
            rdat_q    <= eng_rd_word;
            nv_q      <= 1'b0;
            pend_rd_q <= 1'b0;
         end
         // A new read may start in the cycle its predecessor reports done.
         if (launch && launch_rd) begin
            nv_q      <= 1'b1;
            pend_rd_q <= 1'b1;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         IDX_CFG:  reg_rdata = {cfg_rst_q, {(31-DIV_W){1'b0}}, cfg_div_q};
         IDX_CMD:  reg_rdata = {31'd0, cmd_q};
         IDX_ADDR: reg_rdata = {19'd0, phy_q, 3'd0, regn_q};
         IDX_WDAT: reg_rdata = {{(32-DATA_W){1'b0}}, wdat_q};
         IDX_RDAT: reg_rdata = {{(32-DATA_W){1'b0}}, rdat_q};
         IDX_IND:  reg_rdata = {29'd0, nv_q, 1'b0, eng_busy};
         default:  reg_rdata = '0;
      endcase
   end

   assign soft_rst = cfg_rst_q;
   assign div_sel  = cfg_div_q;
   assign phy_num  = phy_q;
   assign reg_num  = regn_q;
   assign wr_data  = reg_wdata[DATA_W-1:0];

   assert_nv_drops_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(nv_q) |-> !eng_busy);

   assert_no_launch_in_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rst_q && $past(cfg_rst_q)) |-> !eng_busy);
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
   import mdio_pkg::*;
#(
   parameter int DIV_W    = 3,
   parameter int PRESCALE = 4,
   parameter int PRE_LEN  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);
   generate
      if (DIV_W < 1 || DIV_W > 8) begin : g_bad_div
         $error("DIV_W must lie in 1..8");
      end
      if (PRESCALE < 1) begin : g_bad_pre
         $error("PRESCALE must be at least 1");
      end
      if (PRE_LEN < 1 || PRE_LEN > 64) begin : g_bad_len
         $error("PRE_LEN must lie in 1..64");
      end
   endgenerate

   logic              soft_rst;
   logic [DIV_W-1:0]  div_sel;
   logic              launch;
   logic              launch_rd;
   logic [PHY_AW-1:0] phy_num;
   logic [PHY_AW-1:0] reg_num;
   logic [DATA_W-1:0] wr_data;
   logic              eng_busy;
   logic              eng_done;
   logic [DATA_W-1:0] rd_word;
   logic              mdc_rise;
   logic              mdc_fall;

   mdio_reg_bank #(.DIV_W(DIV_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_busy(eng_busy),
      .eng_done(eng_done), .eng_rd_word(rd_word), .soft_rst(soft_rst),
      .div_sel(div_sel), .launch(launch), .launch_rd(launch_rd),
      .phy_num(phy_num), .reg_num(reg_num), .wr_data(wr_data)
   );

   mdio_clk_div #(.DIV_W(DIV_W), .PRESCALE(PRESCALE)) u_clk (
      .clk(clk), .rst_n(rst_n), .hold(soft_rst), .div_sel(div_sel),
      .mdc(mdc), .mdc_rise(mdc_rise), .mdc_fall(mdc_fall)
   );

   mdio_frame_engine #(.PRE_LEN(PRE_LEN)) u_eng (
      .clk(clk), .rst_n(rst_n), .abort(soft_rst), .launch(launch),
      .launch_rd(launch_rd), .phy_num(phy_num), .reg_num(reg_num),
      .wr_data(wr_data), .mdc_rise(mdc_rise), .mdc_fall(mdc_fall),
      .mdio_i(mdio_i), .busy(eng_busy), .done(eng_done), .rd_word(rd_word),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe)
   );

   assert_soft_reset_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (!eng_busy && !mdio_oe && !mdc));

   assert_data_moves_mdc_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mdio_oe && $past(mdio_oe) && !$stable(mdio_o)) |-> !mdc);
endmodule

// File: tb/mdio_mgmt_ctrl_tb_top.sv
module mdio_mgmt_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = 32'd0;
   logic [31:0] reg_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   int checks = 0;
   int fails  = 0;

   logic [63:0] cap_bits = 64'd0;
   logic [63:0] cap_oe   = 64'd0;
   int          edges    = 64;
   logic [15:0] phy_resp = 16'd0;
   bit          phy_rd   = 1'b0;

   always #10 clk = ~clk;

   mdio_mgmt_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   // PHY model: samples on rising MDC, answers after falling MDC.
   always @(posedge mdc) begin
      if (edges < 64 && (edges > 0 || mdio_oe)) begin
         cap_bits = {cap_bits[62:0], mdio_o};
         cap_oe   = {cap_oe[62:0], mdio_oe};
         edges    = edges + 1;
      end
   end

   always @(negedge mdc) begin
      if (phy_rd && edges >= 48 && edges < 64) mdio_i = phy_resp[63 - edges];
      else mdio_i = 1'b1;
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] idx, input logic [31:0] d);
      @(negedge clk);
      reg_addr = idx; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] idx, output logic [31:0] d);
      @(negedge clk);
      reg_addr = idx;
      #1 d = reg_rdata;
   endtask

   function automatic logic [63:0] exp_frame(bit r, logic [4:0] p, logic [4:0] g, logic [15:0] d);
      return {32'hFFFF_FFFF, 2'b01, (r ? 2'b10 : 2'b01), p, g, 2'b10, (r ? 16'h0 : d)};
   endfunction

   task automatic wait_idle(input logic [31:0] mask);
      logic [31:0] v;
      for (int i = 0; i < 20000; i++) begin
         rd(3'd5, v);
         if ((v & mask) == 0) break;
      end
   endtask

   task automatic do_write(input logic [4:0] p, input logic [4:0] g, input logic [15:0] d);
      logic [31:0] v;
      wr(3'd2, {19'd0, p, 3'd0, g});
      phy_rd = 1'b0; edges = 0;
      wr(3'd3, {16'hDEAD, d});
      rd(3'd5, v);
      chk("R4 busy after write launch", v, 32'h1);
      wait_idle(32'h1);
      chk("R2 write frame bits", cap_bits, exp_frame(1'b0, p, g, d));
      chk("R2 write frame driven", cap_oe, 64'hFFFF_FFFF_FFFF_FFFF);
   endtask

   task automatic do_read(input logic [4:0] p, input logic [4:0] g, input logic [15:0] resp);
      logic [31:0] v;
      logic [63:0] e;
      wr(3'd2, {19'd0, p, 3'd0, g});
      phy_resp = resp; phy_rd = 1'b1; edges = 0;
      wr(3'd1, 32'd0);
      wr(3'd1, 32'd1);
      rd(3'd5, v);
      chk("R5 busy and not-valid at read launch", v, 32'h5);
      wait_idle(32'h5);
      rd(3'd4, v);
      chk("R3 read data", v, {16'd0, resp});
      e = exp_frame(1'b1, p, g, 16'h0);
      chk("R3 read header", {18'd0, cap_bits[63:18]}, {18'd0, e[63:18]});
      chk("R3 read release from turnaround", cap_oe, {{46{1'b1}}, 18'd0});
      phy_rd = 1'b0;
   endtask

   task automatic mdc_period(input int exp_cyc, input string req);
      realtime t1, t2;
      @(posedge mdc); t1 = $realtime;
      @(posedge mdc); t2 = $realtime;
      chk(req, 64'(int'((t2 - t1) / 20.0)), 64'(exp_cyc));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'h5EED_0042));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values and map
      rd(3'd0, v); chk("R1 cfg reset", v, 32'h7);
      rd(3'd1, v); chk("R1 cmd reset", v, 32'h0);
      rd(3'd2, v); chk("R1 addr reset", v, 32'h0);
      rd(3'd4, v); chk("R1 rdata reset", v, 32'h0);
      rd(3'd5, v); chk("R1 ind reset", v, 32'h0);
      wr(3'd2, 32'hFFFF_FFFF);
      rd(3'd2, v); chk("R1 addr fields", v, 32'h0000_1F1F);
      rd(3'd6, v); chk("R1 unused index", v, 32'h0);

      // R7 divider
      mdc_period(64, "R7 period setting 7");
      wr(3'd0, 32'h2);
      mdc_period(24, "R7 period setting 2");
      wr(3'd0, 32'h0);
      mdc_period(8, "R7 period setting 0");

      // Directed corners
      do_write(5'd31, 5'd31, 16'hFFFF);
      do_write(5'd0, 5'd0, 16'h0000);
      do_read(5'd1, 5'd2, 16'hA5A5);
      do_read(5'd31, 5'd0, 16'hFFFF);

      // R6: cmd already 1
      wr(3'd1, 32'd1);
      rd(3'd5, v); chk("R6 no relaunch when cmd held", v, 32'h0);
      repeat (40) @(negedge clk);
      chk("R6 bus quiet", {63'd0, mdio_oe}, 64'd0);

      // Random frames (R2, R3)
      for (int i = 0; i < 5; i++) begin
         do_write(5'($urandom), 5'($urandom), 16'($urandom));
         do_read(5'($urandom), 5'($urandom), 16'($urandom));
      end

      // R10: launch attempt while busy
      wr(3'd2, {19'd0, 5'd9, 3'd0, 5'd3});
      phy_rd = 1'b0; edges = 0;
      wr(3'd3, 32'h1234);
      repeat (50) @(negedge clk);
      wr(3'd3, 32'hBEEF);
      wait_idle(32'h1);
      chk("R10 frame kept first data", cap_bits, exp_frame(1'b0, 5'd9, 5'd3, 16'h1234));
      repeat (100) @(negedge clk);
      rd(3'd5, v); chk("R10 no second frame", v, 32'h0);

      // R8 soft reset abort
      edges = 0;
      wr(3'd3, 32'h00F0);
      repeat (150) @(negedge clk);
      wr(3'd0, 32'h8000_0000);
      repeat (2) @(negedge clk);
      chk("R8 oe released", {63'd0, mdio_oe}, 64'd0);
      chk("R8 mdc low", {63'd0, mdc}, 64'd0);
      rd(3'd5, v); chk("R8 busy cleared", v, 32'h0);
      wr(3'd3, 32'h0001);
      rd(3'd5, v); chk("R8 no launch in soft reset", v, 32'h0);
      repeat (30) @(negedge clk);
      chk("R8 mdc held low", {63'd0, mdc}, 64'd0);
      rd(3'd0, v); chk("R1 cfg readback", v, 32'h8000_0000);
      wr(3'd0, 32'h0);
      do_write(5'd4, 5'd17, 16'h5A0F);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule